// File: doc/BRIEF.md
# On-Chip Temperature Sensor Sequencer

This block drives an on-chip temperature sensor from two 32-bit control registers. Software can switch the sensor's supply on or off and can start a conversion. It also sets a 12-bit alarm threshold and a repeat period counted in ticks of a slow real-time clock. The sensor front end sits behind a start/done/count handshake. For each finished conversion the block stores the 12-bit count and sets a ready flag. It also compares the count with the threshold and updates an alarm output. A lower count means a hotter die, so the alarm fires when the count is at or below the threshold.

Each register is reachable through four write aliases: plain write, bit-set, bit-clear and bit-toggle. Software can therefore change one field without a read-modify-write. When the period is zero the sequencer makes one conversion and then drops its start bit. Otherwise it keeps converting until the start bit is cleared or the sensor is powered down.

Top module: `tsmon_top`

## Requirements
- R1: The address `bus_addr[2]` selects the register (0 = control, 1 = period). `bus_addr[1:0]` selects the write alias: 0 writes the data, 1 ORs it in, 2 clears the bits set in the data, 3 XORs it in. A read returns the register value whatever the alias bits.
- R2: Control register layout is as follows. Bit 0 is power-down and bit 1 is start. Bit 2 is the ready flag. Bits 19:8 hold the captured count and bits 31:20 the alarm threshold. Bits 7:3 read 0. The period register holds the period in bits 15:0, and bits 31:16 read 0. Writes to the ready flag and to the count field are ignored.
- R3: After reset the control register reads 0x00000001 and the period register reads 0. `temp_alarm`, `sens_start` and `sens_pwr_en` are 0.
- R4: `sens_pwr_en` is the inverse of power-down. While power-down is 1 the start bit cannot become 1 and no conversion starts.
- R5: A write that takes the start bit from 0 to 1 while power-down ends at 0 starts a conversion. `sens_start` is then high for exactly one cycle, the cycle after the write edge, and the ready flag reads 0 from that cycle on.
- R6: When `sens_done` is sampled during a conversion, `sens_count` is stored in the count field and the ready flag reads 1 from the next cycle. A `sens_done` outside a conversion changes nothing.
- R7: With period 0, the start bit reads 0 once the result is stored, and no further `sens_start` follows.
- R8: With period N > 0 and the start bit still 1, the next `sens_start` comes in the cycle after the N-th `rtc_tick` that follows the cycle of `sens_done`. Clearing the start bit stops the repetition.
- R9: At each capture `temp_alarm` is set if the count is at or below the threshold and cleared otherwise. It holds its value between captures.
- R10: Setting power-down during a conversion aborts it. The start bit drops, later `sens_done` pulses are ignored, the count field keeps its old value and the ready flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register select and alias select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational from the address) |
| rtc_tick | input | 1 | Single-cycle slow-clock tick, already synchronous |
| sens_pwr_en | output | 1 | Sensor supply enable |
| sens_start | output | 1 | One-cycle conversion start |
| sens_done | input | 1 | Conversion complete strobe |
| sens_count | input | 12 | Conversion result |
| temp_alarm | output | 1 | Count at or below threshold at the last capture |

## Verification
Every register write lands on the clock edge that samples `bus_wr`. The start pulse, the start bit and the power enable therefore change in the cycle that directly follows that edge. The bench checks them at the falling edge that ends the write task. The stored count, the ready flag and the alarm change one edge after `sens_done` is sampled. The bench polls the ready flag before it compares any result. A repeated start is due in the cycle after the N-th counted tick. A falling-edge monitor counts ticks from the `sens_done` cycle, not including that cycle, up to the cycle in which `sens_start` shows, and expects exactly N.

// File: rtl/tsmon_pkg.sv
package tsmon_pkg;
    localparam int DATA_W  = 32;
    localparam int CNT_W   = 12;
    localparam int FREQ_W  = 16;
    localparam int PD_BIT  = 0;
    localparam int GO_BIT  = 1;
    localparam int FIN_BIT = 2;
    localparam int CNT_LSB = 8;
    localparam int THR_LSB = 20;

    typedef enum logic [1:0] {
        AL_BASE = 2'd0,
        AL_SET  = 2'd1,
        AL_CLR  = 2'd2,
        AL_TOG  = 2'd3
    } alias_e;

    typedef enum logic [1:0] {
        CS_IDLE = 2'd0,
        CS_BUSY = 2'd1,
        CS_WAIT = 2'd2
    } conv_st_e;

    function automatic logic [DATA_W-1:0] alias_apply(
        input alias_e            al,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wd
    );
        logic [DATA_W-1:0] res;
        case (al)
            AL_SET:  res = cur | wd;
            AL_CLR:  res = cur & ~wd;
            AL_TOG:  res = cur ^ wd;
            default: res = wd;
        endcase
        return res;
    endfunction

    function automatic logic [DATA_W-1:0] ctl_pack(
        input logic [CNT_W-1:0] thr,
        input logic [CNT_W-1:0] cnt,
        input logic             fin,
        input logic             go,
        input logic             pd
    );
        return {thr, cnt, 5'b0, fin, go, pd};
    endfunction
endpackage

// File: rtl/tsmon_pacer.sv
module tsmon_pacer #(
    parameter int FREQ_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic [FREQ_W-1:0] period,
    output logic              fire
);
    logic [FREQ_W-1:0] cnt_q;
    logic [FREQ_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    assign fire    = en && tick && (cnt_inc >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_inc[FREQ_W-1:0];
        end
    end
endmodule

// File: rtl/tsmon_regs.sv
module tsmon_regs
    import tsmon_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int FW = FREQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CW-1:0]     cnt_in,
    input  logic              fin_in,
    input  logic              hw_clr_go,
    output logic [DATA_W-1:0] rdata,
    output logic              pd_q,
    output logic              pd_next,
    output logic              go_q,
    output logic              go_pulse,
    output logic [CW-1:0]     thr_q,
    output logic [FW-1:0]     period_q
);
    logic [DATA_W-1:0] r0_cur, r1_cur, r0_new, r1_new;
    logic              wr0, wr1, go_wr, go_next;
    alias_e            al;
    logic              unused_bits;

    always_comb begin
        al      = alias_e'(addr[1:0]);
        r0_cur  = ctl_pack(thr_q, cnt_in, fin_in, go_q, pd_q);
        r1_cur  = DATA_W'(period_q);
        r0_new  = alias_apply(al, r0_cur, wdata);
        r1_new  = alias_apply(al, r1_cur, wdata);
        wr0     = wr_en && !addr[2];
        wr1     = wr_en && addr[2];
        pd_next = wr0 ? r0_new[PD_BIT] : pd_q;
        go_wr   = wr0 ? r0_new[GO_BIT] : go_q;
        go_next = go_wr && !pd_next && !hw_clr_go;
        go_pulse = wr0 && r0_new[GO_BIT] && !go_q && !pd_next;
        rdata   = addr[2] ? r1_cur : r0_cur;
    end

    assign unused_bits = ^{r0_new[THR_LSB-1:FIN_BIT], r1_new[DATA_W-1:FW]};

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_q     <= 1'b1;
            go_q     <= 1'b0;
            thr_q    <= '0;
            period_q <= '0;
        end else begin
            pd_q <= pd_next;
            go_q <= go_next;
            if (wr0) thr_q    <= r0_new[THR_LSB +: CW];
            if (wr1) period_q <= r1_new[FW-1:0];
        end
    end

    AST_ONESHOT_CLR: assert property (@(posedge clk) disable iff (rst) hw_clr_go |=> !go_q); // R7
    AST_GO_NEEDS_POWER: assert property (@(posedge clk) disable iff (rst) go_q |-> !pd_q); // R4
endmodule

// File: rtl/tsmon_conv.sv
module tsmon_conv
    import tsmon_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int FW = FREQ_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pd_next,
    input  logic          run,
    input  logic          go_pulse,
    input  logic [FW-1:0] period,
    input  logic [CW-1:0] thr,
    input  logic          fire,
    input  logic          sens_done,
    input  logic [CW-1:0] sens_count,
    output logic          start_q,
    output logic [CW-1:0] cnt_q,
    output logic          fin_q,
    output logic          alarm_q,
    output logic          waiting,
    output logic          hw_clr_go
);
    conv_st_e st_q;
    logic     capture;

    assign capture   = (st_q == CS_BUSY) && sens_done && !pd_next;
    assign hw_clr_go = capture && (period == '0);
    assign waiting   = (st_q == CS_WAIT);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CS_IDLE;
            start_q <= 1'b0;
            cnt_q   <= '0;
            fin_q   <= 1'b0;
            alarm_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            if (pd_next) begin
                st_q <= CS_IDLE;
            end else begin
                case (st_q)
                    CS_IDLE: begin
                        if (go_pulse) begin
                            st_q    <= CS_BUSY;
                            start_q <= 1'b1;
                            fin_q   <= 1'b0;
                        end
                    end
                    CS_BUSY: begin
                        if (capture) begin
                            cnt_q   <= sens_count;
                            fin_q   <= 1'b1;
                            alarm_q <= (sens_count <= thr);
                            if (period == '0 || !run) st_q <= CS_IDLE;
                            else                      st_q <= CS_WAIT;
                        end
                    end
                    CS_WAIT: begin
                        if (!run) begin
                            st_q <= CS_IDLE;
                        end else if (fire) begin
                            st_q    <= CS_BUSY;
                            start_q <= 1'b1;
                            fin_q   <= 1'b0;
                        end
                    end
                    default: st_q <= CS_IDLE;
                endcase
            end
        end
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst) start_q |=> !start_q); // R5
    AST_FIN_LOW_AT_START: assert property (@(posedge clk) disable iff (rst) start_q |-> !fin_q); // R5
    AST_CAPTURE_SETS_FIN: assert property (@(posedge clk) disable iff (rst) capture |=> fin_q); // R6
    AST_PD_IDLE: assert property (@(posedge clk) disable iff (rst) pd_next |=> (st_q == CS_IDLE && !start_q)); // R10
endmodule

// File: rtl/tsmon_top.sv
module tsmon_top
    import tsmon_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int FW = FREQ_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rtc_tick,
    output logic              sens_pwr_en,
    output logic              sens_start,
    input  logic              sens_done,
    input  logic [CW-1:0]     sens_count,
    output logic              temp_alarm
);
    logic          pd_q, pd_next, go_q, go_pulse, hw_clr_go;
    logic          fin, waiting, fire;
    logic [CW-1:0] cnt, thr;
    logic [FW-1:0] period;

    tsmon_regs #(.CW(CW), .FW(FW)) i_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .cnt_in(cnt), .fin_in(fin), .hw_clr_go(hw_clr_go), .rdata(bus_rdata),
        .pd_q(pd_q), .pd_next(pd_next), .go_q(go_q), .go_pulse(go_pulse),
        .thr_q(thr), .period_q(period)
    );

    tsmon_pacer #(.FREQ_W(FW)) i_pacer (
        .clk(clk), .rst(rst), .en(waiting), .tick(rtc_tick), .period(period), .fire(fire)
    );

    tsmon_conv #(.CW(CW), .FW(FW)) i_conv (
        .clk(clk), .rst(rst), .pd_next(pd_next), .run(go_q), .go_pulse(go_pulse),
        .period(period), .thr(thr), .fire(fire), .sens_done(sens_done),
        .sens_count(sens_count), .start_q(sens_start), .cnt_q(cnt), .fin_q(fin),
        .alarm_q(temp_alarm), .waiting(waiting), .hw_clr_go(hw_clr_go)
    );

    assign sens_pwr_en = !pd_q;

    AST_START_POWERED: assert property (@(posedge clk) disable iff (rst) sens_start |-> sens_pwr_en); // R4
endmodule

// File: tb/test_tsmon_top.sv
module test_tsmon_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rtc_tick = 1'b0;
    logic        sens_pwr_en, sens_start, temp_alarm;
    logic        sens_done = 1'b0;
    logic [11:0] sens_count = '0;

    int n_chk = 0, n_err = 0;
    int lat_cfg = 3, pend = 0, n_starts = 0, cyc = 0;
    int tick_div = 4, exp_gap = 0, n_gaps = 0, gap_acc = 0;
    bit tick_en = 0, per_mode = 0, armed = 0, inject = 0;
    logic [11:0] next_val = '0;

    always #5 clk = ~clk;

    tsmon_top i_tsmon_top (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rtc_tick(rtc_tick), .sens_pwr_en(sens_pwr_en),
        .sens_start(sens_start), .sens_done(sens_done), .sens_count(sens_count),
        .temp_alarm(temp_alarm)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] alias_ref(input int al, input logic [31:0] cur, input logic [31:0] wd);
        case (al)
            1:       return cur | wd;
            2:       return cur & ~wd;
            3:       return cur ^ wd;
            default: return wd;
        endcase
    endfunction

    function automatic logic [31:0] ctl_ref(input logic [11:0] thr, input logic [11:0] cnt,
                                            input logic fin, input logic go, input logic pd);
        return {thr, cnt, 5'b0, fin, go, pd};
    endfunction

    // sensor model, tick source and periodic-gap monitor
    always @(negedge clk) begin
        cyc++;
        if (sens_done) begin
            armed = per_mode;
            gap_acc = 0;
        end else begin
            if (rtc_tick && armed) gap_acc++;
            if (sens_start && armed) begin
                chk("R8 tick gap", gap_acc, exp_gap);
                n_gaps++;
                armed = 0;
            end
        end
        if (sens_start) n_starts++;
        sens_done = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                sens_done  = 1'b1;
                sens_count = next_val;
            end
        end
        if (sens_start) pend = lat_cfg;
        if (inject) begin
            sens_done  = 1'b1;
            sens_count = 12'hABC;
            inject     = 0;
        end
        rtc_tick = tick_en && (cyc % tick_div == 0);
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wait_fin();
        logic [31:0] v;
        for (int i = 0; i < 200; i++) begin
            rd(3'd0, v);
            if (v[2]) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [31:0] v, wd, r0_exp, r1_exp;
        logic [11:0] m_thr, m_cnt, t, c;
        logic        m_fin;
        int          al, s0;
        void'($urandom(32'd1234));
        m_thr = '0; m_cnt = '0; m_fin = 1'b0; r1_exp = '0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        // R3 reset state
        rd(3'd0, v); chk("R3 ctl reset", v, 32'h1);
        rd(3'd4, v); chk("R3 period reset", v, 32'h0);
        chk("R3 alarm", temp_alarm, 0);
        chk("R3 pwr_en", sens_pwr_en, 0);
        chk("R3 start", sens_start, 0);

        // R4: start while powered down is refused
        s0 = n_starts;
        wr(3'd1, 32'h2);
        chk("R4 no pulse", sens_start, 0);
        rd(3'd0, v); chk("R4 start bit stays 0", v, 32'h1);
        repeat (5) @(negedge clk);
        chk("R4 no conversion", n_starts, s0);

        // R1 / R2: random alias writes with the sensor off
        for (int i = 0; i < 40; i++) begin
            al = $urandom % 4;
            wd = $urandom;
            if ($urandom % 2 == 0) begin
                if (al == 0) wd[0] = 1'b1;
                else if (al != 1) wd[0] = 1'b0;
                wr({1'b0, al[1:0]}, wd);
                m_thr = alias_ref(al, {20'h0, m_thr}, {20'h0, wd[31:20]})[11:0];
                r0_exp = ctl_ref(m_thr, m_cnt, m_fin, 1'b0, 1'b1);
                rd({1'b0, 2'($urandom % 4)}, v);
                chk("R1 R2 ctl alias", v, r0_exp);
            end else begin
                wr({1'b1, al[1:0]}, wd);
                r1_exp = {16'h0, alias_ref(al, r1_exp, {16'h0, wd[15:0]})[15:0]};
                rd({1'b1, 2'($urandom % 4)}, v);
                chk("R1 R2 period alias", v, r1_exp);
            end
        end

        // power up, one-shot mode
        wr(3'd4, 32'h0);
        wr(3'd2, 32'h1);
        chk("R4 pwr_en on", sens_pwr_en, 1);

        // directed: count equal to threshold, then one above
        m_thr = 12'h400;
        wr(3'd0, {m_thr, 20'h0});
        next_val = 12'h400; lat_cfg = 4;
        s0 = n_starts;
        wr(3'd1, 32'h2);
        chk("R5 start pulse", sens_start, 1);
        rd(3'd0, v);
        chk("R5 single cycle", sens_start, 0);
        chk("R5 ready low", v[2], 0);
        wait_fin();
        rd(3'd0, v);
        chk("R6 capture", v, ctl_ref(m_thr, 12'h400, 1'b1, 1'b0, 1'b0));
        chk("R9 alarm at equal", temp_alarm, 1);
        repeat (30) @(negedge clk);
        chk("R7 one pulse only", n_starts, s0 + 1);
        rd(3'd0, v); chk("R7 start bit cleared", v[1], 0);

        next_val = 12'h401;
        wr(3'd1, 32'h2);
        wait_fin();
        chk("R9 alarm above", temp_alarm, 0);
        m_cnt = 12'h401;

        // R6: stray done while idle is ignored
        inject = 1;
        repeat (4) @(negedge clk);
        rd(3'd0, v);
        chk("R6 stray done ignored", v, ctl_ref(m_thr, m_cnt, 1'b1, 1'b0, 1'b0));
        chk("R9 alarm held", temp_alarm, 0);

        // random one-shots
        for (int i = 0; i < 24; i++) begin
            t = 12'($urandom);
            case ($urandom % 4)
                0: c = t;
                1: c = t + 12'd1;
                2: c = t - 12'd1;
                default: c = 12'($urandom);
            endcase
            lat_cfg = 1 + $urandom % 6;
            next_val = c;
            wr(3'd0, {t, 20'h0});
            wr(3'd1, 32'h2);
            wait_fin();
            rd(3'd0, v);
            chk("R6 random capture", v, ctl_ref(t, c, 1'b1, 1'b0, 1'b0));
            chk("R9 random alarm", temp_alarm, (c <= t) ? 32'd1 : 32'd0);
            m_thr = t; m_cnt = c;
        end

        // R8 periodic
        next_val = 12'h123; lat_cfg = 3;
        exp_gap = 3; n_gaps = 0; per_mode = 1; tick_en = 1;
        wr(3'd4, 32'd3);
        wr(3'd1, 32'h2);
        for (int i = 0; i < 400 && n_gaps < 3; i++) @(negedge clk);
        chk("R8 repeats seen", (n_gaps >= 3) ? 32'd1 : 32'd0, 32'd1);
        wr(3'd2, 32'h2);
        per_mode = 0; armed = 0;
        repeat (20) @(negedge clk);
        s0 = n_starts;
        repeat (80) @(negedge clk);
        chk("R8 stop after clear", n_starts, s0);
        rd(3'd0, v); chk("R8 start bit 0", v[1], 0);
        m_cnt = 12'h123;
        tick_en = 0;

        // R10 abort by power-down
        wr(3'd4, 32'h0);
        next_val = 12'h777; lat_cfg = 20;
        wr(3'd1, 32'h2);
        repeat (5) @(negedge clk);
        wr(3'd1, 32'h1);
        chk("R10 pwr off", sens_pwr_en, 0);
        repeat (30) @(negedge clk);
        rd(3'd0, v);
        chk("R10 abort keeps count", v, ctl_ref(m_thr, m_cnt, 1'b0, 1'b0, 1'b1));

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule